// File: doc/BRIEF.md
# Multiphase Clock-Select Phase Stepper

This block moves the phase of a recovered read clock in steps of 1/r UI without running any logic at the very high clock rate that pulse deletion would need. A source outside the block supplies r clocks of equal frequency, each lagging the one before it by 1/r UI. The block keeps a pointer to one of them and drives a one-hot select that feeds a glitch-free clock multiplexer. Moving the pointer from clock i to clock (i+1) mod r delays the output by 1/r UI, which is the same as removing one fast pulse. Moving it to (i-1) mod r advances the output by 1/r UI, which is the same as adding one fast pulse. The residual jitter of the selected clock is therefore about 1/r UI.

Lag and lead request strobes come from a scheduler, for example the one that decides where deletions go. A request is first recorded in a small signed backlog. The pointer moves only in a cycle flagged by `safe_en`, the enable that marks a safe switching instant of the output clock, and it moves at most one position per such cycle. A lag and a lead request that arrive in the same cycle cancel each other. When the backlog is full, further requests in the same direction are dropped.

Top module: `phase_stepper`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is `phase_idx` = 0, `sel` = 1 (bit 0 set) and an empty backlog.
- R2: `sel` is always one-hot, and its single set bit is bit number `phase_idx`.
- R3: `phase_idx` and `sel` keep their values after any edge at which `safe_en` was low.
- R4: At an edge with `safe_en` high and a positive backlog (net lag), `phase_idx` becomes `phase_idx`+1, wrapping from NUM_PHASES-1 to 0, and the backlog drops by one.
- R5: At an edge with `safe_en` high and a negative backlog (net lead), `phase_idx` becomes `phase_idx`-1, wrapping from 0 to NUM_PHASES-1, and the backlog rises by one.
- R6: A cycle with `lag_req` and `lead_req` both high adds nothing to the backlog.
- R7: At most one step is taken per `safe_en` cycle. Outstanding requests wait in the backlog and are applied one per later `safe_en` cycle.
- R8: The backlog saturates at +PEND_MAX and -PEND_MAX. A lag request at +PEND_MAX, or a lead request at -PEND_MAX, is dropped.
- R9: A request is recorded in the backlog at the edge where it is sampled, and only the backlog held before that edge decides the step. With an empty backlog, a request coinciding with `safe_en` therefore moves nothing at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| safe_en | input | 1 | Marks a safe switching instant of the output clock |
| lag_req | input | 1 | Request to retard the phase by one step |
| lead_req | input | 1 | Request to advance the phase by one step |
| sel | output | NUM_PHASES | One-hot select for the glitch-free clock mux |
| phase_idx | output | $clog2(NUM_PHASES) | Current phase index |

## Verification
The assertions assume that reset is low at the first clock edge and that every input carries a known 0 or 1 at each sampling edge. Beyond that they accept any mix of request strobes and any spacing of `safe_en`, including `safe_en` held high for many cycles. The bench holds reset low for several edges before it releases it. It drives every input at the falling edge from a seeded random source or from a directed sequence, so none of these assumptions is broken. The random run keeps requests frequent compared with `safe_en`, so the backlog keeps reaching both saturation limits and the pointer keeps wrapping in both directions.

// File: rtl/phase_step_pkg.sv
// Package: shared step direction type for the phase stepper.
// Assumes: nothing beyond a single clock domain.
package phase_step_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LAG  = 2'd1,
        STEP_LEAD = 2'd2
    } step_dir_e;
endpackage

// File: rtl/phase_req_accum.sv
// Module: phase_req_accum
// Keeps the signed backlog of lag (+) and lead (-) requests and chooses the
// step to take when safe_en is high. Opposing requests in one cycle cancel.
// The backlog saturates at +/-PEND_MAX.
// Assumes: the requests are single-cycle strobes sampled every clock.
module phase_req_accum
    import phase_step_pkg::*;
#(
    parameter int PEND_MAX = 3,
    parameter int PEND_W   = $clog2(PEND_MAX + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     safe_en,
    input  logic                     lag_req,
    input  logic                     lead_req,
    output step_dir_e                step_dir,
    output logic signed [PEND_W-1:0] pend_q
);
    localparam int SW = PEND_W + 1;
    localparam logic signed [SW-1:0] P_ONE  = SW'(1);
    localparam logic signed [SW-1:0] P_ZERO = '0;
    localparam logic signed [SW-1:0] P_HI   = SW'(PEND_MAX);
    localparam logic signed [SW-1:0] P_LO   = -SW'(PEND_MAX);

    logic signed [SW-1:0] delta;
    logic signed [SW-1:0] step_val;
    logic signed [SW-1:0] pend_ext;
    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] sum_sat;

    // Net request of this cycle: +1 lag, -1 lead, 0 if both or neither.
    always_comb begin
        if (lag_req && !lead_req)      delta = P_ONE;
        else if (lead_req && !lag_req) delta = -P_ONE;
        else                           delta = P_ZERO;
    end

    // Step decision: uses only the backlog held before this edge.
    always_comb begin
        pend_ext = {pend_q[PEND_W-1], pend_q};
        step_dir = STEP_HOLD;
        step_val = P_ZERO;
        if (safe_en && pend_ext > P_ZERO) begin
            step_dir = STEP_LAG;
            step_val = P_ONE;
        end else if (safe_en && pend_ext < P_ZERO) begin
            step_dir = STEP_LEAD;
            step_val = -P_ONE;
        end
    end

    // Next backlog: retire the taken step, add the new request, saturate.
    always_comb begin
        sum = pend_ext - step_val + delta;
        if (sum > P_HI)      sum_sat = P_HI;
        else if (sum < P_LO) sum_sat = P_LO;
        else                 sum_sat = sum;
    end

    // Backlog register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= sum_sat[PEND_W-1:0];
    end
endmodule

// File: rtl/phase_ptr.sv
// Module: phase_ptr
// Holds the phase index modulo NUM_PHASES and a registered one-hot select.
// Lag moves the index up, lead moves it down, and both wrap around.
// Assumes: step_dir is HOLD except in cycles flagged as safe switching points.
module phase_ptr
    import phase_step_pkg::*;
#(
    parameter int NUM_PHASES = 8,
    parameter int IDX_W      = $clog2(NUM_PHASES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  step_dir_e             step_dir,
    output logic [IDX_W-1:0]      idx_q,
    output logic [NUM_PHASES-1:0] sel_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PHASES - 1);

    logic [IDX_W-1:0] idx_d;

    // Next index: rotate up or down, with an explicit wrap for any r.
    always_comb begin
        unique case (step_dir)
            STEP_LAG:  idx_d = (idx_q == LAST) ? '0 : idx_q + IDX_W'(1);
            STEP_LEAD: idx_d = (idx_q == '0) ? LAST : idx_q - IDX_W'(1);
            default:   idx_d = idx_q;
        endcase
    end

    // Index register, reset to phase 0.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    // One flop per select line, decoded from the next index so sel tracks idx.
    for (genvar k = 0; k < NUM_PHASES; k++) begin : g_sel
        always_ff @(posedge clk) begin
            if (!rst_n) sel_q[k] <= (k == 0);
            else        sel_q[k] <= (idx_d == IDX_W'(k));
        end
    end
endmodule

// File: rtl/phase_stepper.sv
// Module: phase_stepper (top)
// Steps a select pointer among NUM_PHASES staggered clocks. Lag and lead
// requests are queued in a saturating backlog, and one step is applied per
// safe switching instant.
// Assumes: safe_en is produced in the clk domain from the output clock edge.
module phase_stepper
    import phase_step_pkg::*;
#(
    parameter int NUM_PHASES = 8,
    parameter int PEND_MAX   = 3,
    parameter int IDX_W      = $clog2(NUM_PHASES),
    parameter int PEND_W     = $clog2(PEND_MAX + 1) + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  safe_en,
    input  logic                  lag_req,
    input  logic                  lead_req,
    output logic [NUM_PHASES-1:0] sel,
    output logic [IDX_W-1:0]      phase_idx
);
    step_dir_e                step_dir;
    logic signed [PEND_W-1:0] pend_q;

    phase_req_accum #(.PEND_MAX(PEND_MAX), .PEND_W(PEND_W)) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .safe_en  (safe_en),
        .lag_req  (lag_req),
        .lead_req (lead_req),
        .step_dir (step_dir),
        .pend_q   (pend_q)
    );

    phase_ptr #(.NUM_PHASES(NUM_PHASES), .IDX_W(IDX_W)) ptr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_dir (step_dir),
        .idx_q    (phase_idx),
        .sel_q    (sel)
    );
endmodule

// File: rtl/phase_stepper_chk.sv
// Module: phase_stepper_chk
// Property checker attached to phase_stepper through bind.
// Assumes: reset is low at the first clock edge.
module phase_stepper_chk #(
    parameter int NUM_PHASES = 8,
    parameter int PEND_MAX   = 3,
    parameter int IDX_W      = $clog2(NUM_PHASES),
    parameter int PEND_W     = $clog2(PEND_MAX + 1) + 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     safe_en,
    input logic                     lag_req,
    input logic                     lead_req,
    input logic [NUM_PHASES-1:0]    sel,
    input logic [IDX_W-1:0]         phase_idx,
    input logic signed [PEND_W-1:0] pend
);
    function automatic int up1(input int i);
        return (i == NUM_PHASES - 1) ? 0 : i + 1;
    endfunction
    function automatic int dn1(input int i);
        return (i == 0) ? NUM_PHASES - 1 : i - 1;
    endfunction

    // R1: reset leads to index 0, select bit 0 and an empty backlog.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (phase_idx == '0 && sel == NUM_PHASES'(1) && pend == '0));

    // R2: the select is one-hot and agrees with the index.
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sel) && sel[phase_idx]);

    // R3: no movement without a safe switching instant.
    a_r3_hold_unsafe: assert property (@(posedge clk) disable iff (!rst_n)
        !safe_en |=> ($stable(phase_idx) && $stable(sel)));

    // R4: a positive backlog at a safe instant moves the index up by one.
    a_r4_lag_step: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_en && int'(pend) > 0) |=> int'(phase_idx) == up1(int'($past(phase_idx))));

    // R5: a negative backlog at a safe instant moves the index down by one.
    a_r5_lead_step: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_en && int'(pend) < 0) |=> int'(phase_idx) == dn1(int'($past(phase_idx))));

    // R6: opposing requests cancel, so the backlog holds when nothing steps.
    a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
        (lag_req && lead_req && !safe_en) |=> $stable(pend));

    // R7: the index moves by at most one position per edge.
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(phase_idx) == int'($past(phase_idx))
               || int'(phase_idx) == up1(int'($past(phase_idx)))
               || int'(phase_idx) == dn1(int'($past(phase_idx)))));

    // R8: the backlog stays within +/-PEND_MAX.
    a_r8_pend_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pend) <= PEND_MAX && int'(pend) >= -PEND_MAX);

    // R9: an empty backlog never steps, even when safe_en is high.
    a_r9_no_step_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == '0) |=> $stable(phase_idx));
endmodule

bind phase_stepper phase_stepper_chk #(
    .NUM_PHASES(NUM_PHASES),
    .PEND_MAX  (PEND_MAX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .safe_en   (safe_en),
    .lag_req   (lag_req),
    .lead_req  (lead_req),
    .sel       (sel),
    .phase_idx (phase_idx),
    .pend      (pend_q)
);

// File: tb/phase_stepper_tb_top.sv
// Bench: seeded random requests mixed with directed corner cases, compared
// against a cycle model computed by bench functions.
module phase_stepper_tb_top;
    localparam int NP    = 8;
    localparam int PMAX  = 3;
    localparam int IW    = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          safe_en = 1'b0;
    logic          lag_req = 1'b0;
    logic          lead_req = 1'b0;
    logic [NP-1:0] sel;
    logic [IW-1:0] phase_idx;

    int n_tests = 0;
    int n_fail  = 0;
    int m_idx   = 0;
    int m_pend  = 0;
    bit done    = 1'b0;

    phase_stepper #(.NUM_PHASES(NP), .PEND_MAX(PMAX)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .safe_en   (safe_en),
        .lag_req   (lag_req),
        .lead_req  (lead_req),
        .sel       (sel),
        .phase_idx (phase_idx)
    );

    always #4 clk = ~clk;

    // Step chosen from the backlog held before the edge (R9).
    function automatic int f_step(input int pend, input bit safe);
        if (!safe)    return 0;
        if (pend > 0) return 1;
        if (pend < 0) return -1;
        return 0;
    endfunction

    // Index after a step, with wrap in both directions (R4, R5).
    function automatic int f_next_idx(input int idx, input int st);
        return (idx + st + NP) % NP;
    endfunction

    // Backlog after retiring the step, adding the request and saturating (R6, R8).
    function automatic int f_next_pend(input int pend, input int st, input bit lg, input bit ld);
        int s;
        s = pend - st + ((lg && !ld) ? 1 : 0) - ((ld && !lg) ? 1 : 0);
        if (s > PMAX)  s = PMAX;
        if (s < -PMAX) s = -PMAX;
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model, compare after the edge.
    task automatic cyc(input bit lg, input bit ld, input bit sf);
        int st;
        string tag;
        @(negedge clk);
        lag_req = lg; lead_req = ld; safe_en = sf;
        @(posedge clk);
        st = f_step(m_pend, sf);
        m_idx  = f_next_idx(m_idx, st);
        m_pend = f_next_pend(m_pend, st, lg, ld);
        #1;
        tag = (st > 0) ? "R4" : (st < 0) ? "R5" : "R3";
        check(tag, int'(phase_idx), m_idx);
        check("R2", int'(sel), 1 << m_idx);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int start;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1;
        check("R1", int'(phase_idx), 0);
        check("R1", int'(sel), 1);
        @(negedge clk);
        rst_n = 1'b1;

        // R4 wrap: nine lags, each applied at the next safe instant.
        for (int i = 0; i < NP + 1; i++) begin
            cyc(1, 0, 0);
            cyc(0, 0, 1);
        end
        check("R4", int'(phase_idx), 1);

        // R5 wrap: two leads take the index from 1 through 0 to NP-1.
        for (int i = 0; i < 2; i++) begin
            cyc(0, 1, 0);
            cyc(0, 0, 1);
        end
        check("R5", int'(phase_idx), NP - 1);

        // R6: simultaneous requests cancel, so later safe instants move nothing.
        start = int'(phase_idx);
        cyc(1, 1, 0);
        cyc(0, 0, 1);
        cyc(0, 0, 1);
        check("R6", int'(phase_idx), start);

        // R9: a request with safe_en and an empty backlog does not step at that edge.
        cyc(1, 0, 1);
        check("R9", int'(phase_idx), start);
        cyc(0, 0, 1);
        check("R9", int'(phase_idx), (start + 1) % NP);

        // R8 and R7: six lags saturate at PMAX, then one step per safe instant.
        start = int'(phase_idx);
        for (int i = 0; i < 6; i++) cyc(1, 0, 0);
        cyc(0, 0, 1);
        check("R7", int'(phase_idx), (start + 1) % NP);
        for (int i = 0; i < 7; i++) cyc(0, 0, 1);
        check("R8", int'(phase_idx), (start + PMAX) % NP);

        // R8 negative side: six leads saturate at -PMAX.
        start = int'(phase_idx);
        for (int i = 0; i < 6; i++) cyc(0, 1, 0);
        for (int i = 0; i < 8; i++) cyc(0, 0, 1);
        check("R8", int'(phase_idx), (start - PMAX + NP) % NP);

        // Random mix of requests and safe instants.
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 3) == 0);
        end

        // R1: reset again from a non-zero state.
        @(negedge clk);
        rst_n = 1'b0;
        lag_req = 1'b0; lead_req = 1'b0; safe_en = 1'b0;
        @(posedge clk);
        #1;
        check("R1", int'(phase_idx), 0);
        check("R1", int'(sel), 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule